// File: doc/BRIEF.md
# Indexed Widening Saturating Doubling Multiply-Accumulate

This block is the vector datapath for one family of widening multiply-accumulate operations. It takes a 32-bit operation word and three vectors: a first source holding narrow elements, a second source holding narrow elements from which one element per 128-bit segment is chosen by index, and an accumulator holding wide elements. The accumulator is also the destination. Each wide result lane is formed as follows. Either the even or the odd narrow element of the first source is multiplied by the indexed element of the same segment. The product is doubled with saturation. It is then added to, or subtracted from, the old accumulator lane, again with saturation.

Two element sizes are supported: 16-bit sources with 32-bit results, and 32-bit sources with 64-bit results. The vector length is a parameter and must be a multiple of 128. The operation word is decoded inside the block. Its register numbers are returned with the result. A word that matches none of the eight legal forms raises an illegal flag and passes the accumulator through unchanged. All outputs are registered, and each result appears one clock after its valid input.

Top module: `sqdmla_idx`

## Requirements
- R1: A word is legal only when bits 31:24 = 8'h44, bit 23 = 1, bit 21 = 1 and bits 15:13 = 3'b001. For any other word `illegal_o` is 1 and `res_o` equals `acc_i`. For a legal word `illegal_o` is 0.
- R2: When bit 22 = 0, narrow elements are 16 bits and result lanes are 32 bits. The index is {bits 20:19, bit 11}, which gives 0..7. The second-source register is bits 18:16.
- R3: When bit 22 = 1, narrow elements are 32 bits and result lanes are 64 bits. The index is {bit 20, bit 11}, which gives 0..3. The second-source register is bits 19:16.
- R4: Each 128-bit segment uses as its multiplier the narrow element at the index inside that same segment. All result lanes of the segment share it.
- R5: Bit 10 selects the first-source element for result lane j of a segment. When bit 10 = 0 it is narrow element 2j. When bit 10 = 1 it is narrow element 2j+1. The element is treated as signed.
- R6: The doubled product equals 2·n·m, except when both operands equal the narrow signed minimum. In that case it is the wide signed maximum.
- R7: When bit 12 = 0, each lane is acc + doubled product, clamped to the wide signed range.
- R8: When bit 12 = 1, each lane is acc − doubled product, clamped to the wide signed range.
- R9: Outputs are registered. `valid_o` is `valid_i` delayed one clock. The result, flag and register fields update only on a valid input. Reset clears every output to 0.
- R10: `dst_reg_o` is bits 4:0 and `src_n_reg_o` is bits 9:5. `src_m_reg_o` is the second-source register (R2/R3), zero-extended to 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation word and operands are valid |
| insn_i | input | 32 | Operation word |
| src_n_i | input | VLEN | First source, narrow elements |
| src_m_i | input | VLEN | Indexed source, narrow elements |
| acc_i | input | VLEN | Accumulator, wide elements |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Operation word matched no legal form |
| res_o | output | VLEN | Wide result vector |
| dst_reg_o | output | 5 | Destination register number |
| src_n_reg_o | output | 5 | First-source register number |
| src_m_reg_o | output | 5 | Indexed-source register number |

## Verification
The lane assertions assume that operands are ordinary two's-complement values. Given that, a sum of two non-negative values, a sum of two negative values, and a difference of a non-negative value and a negative value each have a known sign that a wrapping datapath would break. The stimulus drives arbitrary operands, including the most negative values and accumulators already at a limit, so those sign checks are exercised at their extremes. The clocked checks assume that `valid_i` stays low during reset. The bench holds it low until reset has been released for several clocks, and it changes inputs only on falling edges.

// File: rtl/sqdmla_pkg.sv
package sqdmla_pkg;
  localparam int unsigned SEG_W = 128;

  typedef struct packed {
    logic       legal;
    logic       wide;   // 32-bit narrow / 64-bit wide form
    logic       sub;
    logic       top;
    logic [2:0] idx;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } dec_t;
endpackage

// File: rtl/sqdmla_dec.sv
module sqdmla_dec
  import sqdmla_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.legal = (insn_i[31:24] == 8'h44) && insn_i[23] && insn_i[21] &&
                  (insn_i[15:13] == 3'b001);
    dec_o.wide  = insn_i[22];
    dec_o.sub   = insn_i[12];
    dec_o.top   = insn_i[10];
    dec_o.rd    = insn_i[4:0];
    dec_o.rn    = insn_i[9:5];
    if (insn_i[22]) begin
      dec_o.idx = {1'b0, insn_i[20], insn_i[11]};
      dec_o.rm  = {1'b0, insn_i[19:16]};
    end else begin
      dec_o.idx = {insn_i[20:19], insn_i[11]};
      dec_o.rm  = {2'b00, insn_i[18:16]};
    end
  end
endmodule

// File: rtl/sqdmla_lane.sv
module sqdmla_lane #(
  parameter int unsigned NW = 16
) (
  input  logic [NW-1:0]   n_i,
  input  logic [NW-1:0]   m_i,
  input  logic [2*NW-1:0] acc_i,
  input  logic            sub_i,
  output logic [2*NW-1:0] res_o
);
  localparam int unsigned WW = 2 * NW;
  localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};
  localparam logic [WW-1:0] W_MAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] W_MIN = {1'b1, {(WW-1){1'b0}}};

  logic signed [WW-1:0] n_x, m_x, prod, dprod;
  logic signed [WW:0]   sum;
  logic                 both_min;

  always_comb begin
    n_x      = $signed({{NW{n_i[NW-1]}}, n_i});
    m_x      = $signed({{NW{m_i[NW-1]}}, m_i});
    prod     = n_x * m_x;
    both_min = (n_i == N_MIN) && (m_i == N_MIN);
    dprod    = both_min ? $signed(W_MAX) : (prod <<< 1);
    if (sub_i) sum = $signed({acc_i[WW-1], acc_i}) - $signed({dprod[WW-1], dprod});
    else       sum = $signed({acc_i[WW-1], acc_i}) + $signed({dprod[WW-1], dprod});
    if (sum[WW] != sum[WW-1]) res_o = sum[WW] ? W_MIN : W_MAX;
    else                      res_o = sum[WW-1:0];
  end

  always_comb begin
    assert_dbl_sign_R6: assert (dprod == '0 || dprod[WW-1] == (n_i[NW-1] ^ m_i[NW-1]));
    if (!sub_i && !acc_i[WW-1] && !dprod[WW-1])
      assert_add_no_wrap_hi_R7: assert (!res_o[WW-1]);
    if (!sub_i && acc_i[WW-1] && dprod[WW-1])
      assert_add_no_wrap_lo_R7: assert (res_o[WW-1]);
    if (sub_i && !acc_i[WW-1] && dprod[WW-1])
      assert_sub_no_wrap_R8: assert (!res_o[WW-1]);
  end
endmodule

// File: rtl/sqdmla_seg.sv
module sqdmla_seg
  import sqdmla_pkg::*;
(
  input  logic [SEG_W-1:0] n_i,
  input  logic [SEG_W-1:0] m_i,
  input  logic [SEG_W-1:0] acc_i,
  input  logic [2:0]       idx_i,
  input  logic             top_i,
  input  logic             sub_i,
  input  logic             wide_i,
  output logic [SEG_W-1:0] res_o
);
  localparam int unsigned L16 = SEG_W / 32;
  localparam int unsigned L32 = SEG_W / 64;

  logic [15:0]      m16;
  logic [31:0]      m32;
  logic [SEG_W-1:0] res16, res32;

  assign m16 = m_i[idx_i*16 +: 16];
  assign m32 = m_i[idx_i[1:0]*32 +: 32];

  for (genvar j = 0; j < L16; j++) begin : g_h
    logic [15:0] n_sel;
    assign n_sel = top_i ? n_i[(2*j+1)*16 +: 16] : n_i[(2*j)*16 +: 16];
    sqdmla_lane #(.NW(16)) u_lane (
      .n_i   (n_sel),
      .m_i   (m16),
      .acc_i (acc_i[j*32 +: 32]),
      .sub_i (sub_i),
      .res_o (res16[j*32 +: 32])
    );
  end

  for (genvar j = 0; j < L32; j++) begin : g_s
    logic [31:0] n_sel;
    assign n_sel = top_i ? n_i[(2*j+1)*32 +: 32] : n_i[(2*j)*32 +: 32];
    sqdmla_lane #(.NW(32)) u_lane (
      .n_i   (n_sel),
      .m_i   (m32),
      .acc_i (acc_i[j*64 +: 64]),
      .sub_i (sub_i),
      .res_o (res32[j*64 +: 64])
    );
  end

  assign res_o = wide_i ? res32 : res16;
endmodule

// File: rtl/sqdmla_idx.sv
module sqdmla_idx
  import sqdmla_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] src_n_i,
  input  logic [VLEN-1:0] src_m_i,
  input  logic [VLEN-1:0] acc_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [VLEN-1:0] res_o,
  output logic [4:0]      dst_reg_o,
  output logic [4:0]      src_n_reg_o,
  output logic [4:0]      src_m_reg_o
);
  localparam int unsigned SEGS = VLEN / SEG_W;

  dec_t            dec;
  logic [VLEN-1:0] res_d;

  sqdmla_dec u_dec (.insn_i(insn_i), .dec_o(dec));

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    sqdmla_seg u_seg (
      .n_i    (src_n_i[s*SEG_W +: SEG_W]),
      .m_i    (src_m_i[s*SEG_W +: SEG_W]),
      .acc_i  (acc_i[s*SEG_W +: SEG_W]),
      .idx_i  (dec.idx),
      .top_i  (dec.top),
      .sub_i  (dec.sub),
      .wide_i (dec.wide),
      .res_o  (res_d[s*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      illegal_o   <= 1'b0;
      res_o       <= '0;
      dst_reg_o   <= '0;
      src_n_reg_o <= '0;
      src_m_reg_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o   <= !dec.legal;
        res_o       <= dec.legal ? res_d : acc_i;
        dst_reg_o   <= dec.rd;
        src_n_reg_o <= dec.rn;
        src_m_reg_o <= dec.rm;
      end
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_illegal_keeps_acc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (res_o == $past(acc_i)));
endmodule

// File: tb/sqdmla_idx_tb_top.sv
`timescale 1ns/1ps
module sqdmla_idx_tb_top;
  localparam int unsigned VLEN = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] src_n_i = '0, src_m_i = '0, acc_i = '0;
  logic            valid_o, illegal_o;
  logic [VLEN-1:0] res_o;
  logic [4:0]      dst_reg_o, src_n_reg_o, src_m_reg_o;

  always #2.5 clk = ~clk;

  sqdmla_idx #(.VLEN(VLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .src_n_i(src_n_i), .src_m_i(src_m_i), .acc_i(acc_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .res_o(res_o),
    .dst_reg_o(dst_reg_o), .src_n_reg_o(src_n_reg_o), .src_m_reg_o(src_m_reg_o)
  );

  typedef struct {
    logic            ill;
    logic [VLEN-1:0] res;
    logic [4:0]      rd, rn, rm;
    string           tag;
  } exp_t;

  exp_t expq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk(bit wide, bit sub, bit top, int ix, int rm, int rn, int rd);
    logic [31:0] w = '0;
    w[31:24] = 8'h44; w[23] = 1'b1; w[22] = wide; w[21] = 1'b1;
    w[15:13] = 3'b001; w[12] = sub; w[10] = top;
    w[9:5] = rn[4:0]; w[4:0] = rd[4:0];
    if (wide) begin w[20] = ix[1]; w[11] = ix[0]; w[19:16] = rm[3:0]; end
    else begin w[20:19] = ix[2:1]; w[11] = ix[0]; w[18:16] = rm[2:0]; end
    return w;
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [VLEN-1:0] n, logic [VLEN-1:0] m,
                                 logic [VLEN-1:0] a, string tag);
    exp_t e;
    bit   wide = w[22];
    int   nb = wide ? 32 : 16;
    int   ix = wide ? {w[20], w[11]} : {w[20:19], w[11]};
    logic signed [65:0] maxv = wide ? 66'sh0_7FFF_FFFF_FFFF_FFFF : 66'sh7FFF_FFFF;
    logic signed [65:0] minv = -maxv - 1;
    e.tag = tag;
    e.rd  = w[4:0];
    e.rn  = w[9:5];
    e.rm  = wide ? {1'b0, w[19:16]} : {2'b0, w[18:16]};
    e.ill = !((w[31:24] == 8'h44) && w[23] && w[21] && (w[15:13] == 3'b001));
    e.res = a;
    if (!e.ill) begin
      for (int s = 0; s < VLEN / 128; s++) begin
        for (int j = 0; j < 128 / (2 * nb); j++) begin
          longint nv, mv, av, p;
          logic signed [65:0] dp, t;
          int nbase = s*128 + (2*j + w[10]) * nb;
          int mbase = s*128 + ix * nb;
          int abase = s*128 + j * 2 * nb;
          if (wide) begin
            nv = longint'($signed(n[nbase +: 32]));
            mv = longint'($signed(m[mbase +: 32]));
            av = longint'($signed(a[abase +: 64]));
          end else begin
            nv = longint'($signed(n[nbase +: 16]));
            mv = longint'($signed(m[mbase +: 16]));
            av = longint'($signed(a[abase +: 32]));
          end
          p  = nv * mv;
          dp = 66'(p) * 2;
          if (dp > maxv) dp = maxv;
          t = w[12] ? (66'(av) - dp) : (66'(av) + dp);
          if (t > maxv) t = maxv;
          if (t < minv) t = minv;
          if (wide) e.res[abase +: 64] = t[63:0];
          else      e.res[abase +: 32] = t[31:0];
        end
      end
    end
    return e;
  endfunction

  task automatic check_out();
    if (expq.size() != 0) begin
      exp_t e = expq.pop_front();
      n_vec++;
      if (valid_o !== 1'b1 || illegal_o !== e.ill || res_o !== e.res ||
          dst_reg_o !== e.rd || src_n_reg_o !== e.rn || src_m_reg_o !== e.rm) begin
        n_bad++;
        $display("FAIL %s: valid=%0b ill=%0b res=%h rd=%0d rn=%0d rm=%0d exp ill=%0b res=%h rd=%0d rn=%0d rm=%0d",
                 e.tag, valid_o, illegal_o, res_o, dst_reg_o, src_n_reg_o, src_m_reg_o,
                 e.ill, e.res, e.rd, e.rn, e.rm);
      end
    end else if (valid_o !== 1'b0) begin
      n_vec++; n_bad++;
      $display("FAIL R9: valid_o=%0b exp 0 with no input", valid_o);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [VLEN-1:0] n, logic [VLEN-1:0] m,
                       logic [VLEN-1:0] a, string tag);
    @(negedge clk);
    check_out();
    valid_i = 1'b1; insn_i = w; src_n_i = n; src_m_i = m; acc_i = a;
    expq.push_back(model(w, n, m, a, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    valid_i = 1'b0; insn_i = $urandom; src_n_i = rnd_vec(); acc_i = rnd_vec();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, exp completion");
    finish_run();
  end

  initial begin
    logic [VLEN-1:0] nmin16 = {(VLEN/16){16'h8000}};
    logic [VLEN-1:0] nmin32 = {(VLEN/32){32'h8000_0000}};
    logic [VLEN-1:0] amax32 = {(VLEN/32){32'h7FFF_FFFF}};
    logic [VLEN-1:0] amin32 = {(VLEN/32){32'h8000_0000}};
    logic [VLEN-1:0] amax64 = {(VLEN/64){64'h7FFF_FFFF_FFFF_FFFF}};
    logic [VLEN-1:0] amin64 = {(VLEN/64){64'h8000_0000_0000_0000}};
    logic [31:0] w;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (valid_o !== 1'b0 || illegal_o !== 1'b0 || res_o !== '0 || dst_reg_o !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: valid=%0b ill=%0b res=%h exp all zero", valid_o, illegal_o, res_o);
    end

    // R2 R4 R5 R7 R8: 16-bit form, every index, both halves, both directions
    for (int ix = 0; ix < 8; ix++)
      for (int tp = 0; tp < 2; tp++)
        for (int sb = 0; sb < 2; sb++)
          apply(mk(0, sb[0], tp[0], ix, $urandom, $urandom, $urandom),
                rnd_vec(), rnd_vec(), rnd_vec(), "R2/R4/R5 narrow sweep");
    // R3 R4 R5: 64-bit form
    for (int ix = 0; ix < 4; ix++)
      for (int tp = 0; tp < 2; tp++)
        for (int sb = 0; sb < 2; sb++)
          apply(mk(1, sb[0], tp[0], ix, $urandom, $urandom, $urandom),
                rnd_vec(), rnd_vec(), rnd_vec(), "R3/R4/R5 wide sweep");
    idle();

    // R6: both operands most negative
    for (int sb = 0; sb < 2; sb++) begin
      apply(mk(0, sb[0], 0, 3, 1, 2, 3), nmin16, nmin16, '0, "R6 narrow min*min");
      apply(mk(1, sb[0], 1, 2, 9, 4, 5), nmin32, nmin32, '0, "R6 wide min*min");
      apply(mk(0, sb[0], 1, 7, 2, 6, 7), nmin16, nmin16, rnd_vec(), "R6 narrow min*min acc");
      apply(mk(1, sb[0], 0, 1, 3, 8, 9), nmin32, nmin32, rnd_vec(), "R6 wide min*min acc");
    end
    // R7: add saturation at maximum
    apply(mk(0, 0, 0, 0, 0, 0, 0), nmin16, nmin16, amax32, "R7 narrow sat max");
    apply(mk(1, 0, 1, 3, 0, 0, 0), nmin32, nmin32, amax64, "R7 wide sat max");
    apply(mk(0, 0, 0, 5, 0, 0, 0), {(VLEN/16){16'h7FFF}}, {(VLEN/16){16'h7FFF}}, amax32, "R7 narrow pos overflow");
    apply(mk(0, 0, 1, 2, 0, 0, 0), {(VLEN/16){16'h8000}}, {(VLEN/16){16'h7FFF}}, amin32, "R7 narrow sat min");
    apply(mk(1, 0, 0, 2, 0, 0, 0), {(VLEN/32){32'h8000_0000}}, {(VLEN/32){32'h7FFF_FFFF}}, amin64, "R7 wide sat min");
    // R8: subtract saturation
    apply(mk(0, 1, 0, 4, 0, 0, 0), nmin16, nmin16, amin32, "R8 narrow sat min");
    apply(mk(1, 1, 1, 0, 0, 0, 0), nmin32, nmin32, amin64, "R8 wide sat min");
    apply(mk(0, 1, 1, 6, 0, 0, 0), {(VLEN/16){16'h8000}}, {(VLEN/16){16'h7FFF}}, amax32, "R8 narrow sat max");
    apply(mk(1, 1, 0, 1, 0, 0, 0), {(VLEN/32){32'h7FFF_FFFF}}, {(VLEN/32){32'h8000_0000}}, amax64, "R8 wide sat max");
    apply(mk(1, 1, 1, 3, 0, 0, 0), nmin32, nmin32, amax64, "R8 wide max minus max");
    idle();

    // R1: each required field broken in turn
    w = mk(0, 0, 0, 1, 1, 1, 1); w[31] = 1'b1;
    apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R1 bad top byte");
    w = mk(1, 1, 0, 1, 1, 1, 1); w[23] = 1'b0;
    apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R1 size bit23 clear");
    w = mk(0, 1, 1, 1, 1, 1, 1); w[21] = 1'b0;
    apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R1 bit21 clear");
    w = mk(1, 0, 1, 1, 1, 1, 1); w[14] = 1'b1;
    apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R1 opcode bits 15:13");
    w = mk(0, 0, 0, 1, 1, 1, 1); w[13] = 1'b0;
    apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R1 opcode bit13 clear");
    apply(mk(1, 0, 0, 0, 0, 0, 0), rnd_vec(), rnd_vec(), rnd_vec(), "R1 legal after illegal");
    idle();
    idle();

    // R10 and random mix of both forms
    for (int k = 0; k < 300; k++) begin
      w = mk($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 31),
             $urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) w = $urandom;
      apply(w, rnd_vec(), rnd_vec(), rnd_vec(), "R10 random mix");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    idle();
    finish_run();
  end
endmodule